// File: doc/BRIEF.md
# Smart Card Transmit Byte FIFO

This block is a two-entry byte queue between a host processor and the serial transmitter that sends bytes to a smart card. The host writes bytes into the tail over a valid/ready handshake. The transmit engine takes bytes from the head over a second valid/ready handshake. Character framing, guard time and driving the card line are handled elsewhere.

The host can also strobe a discard input. This models a host read of the data register. It returns no data. It moves the read pointer past the head entry, so two discards always leave the queue empty. Storage slots are never cleared. A slot changes only when a later accepted write lands in it, so the head output of an empty queue shows whatever byte last sat in the slot the read pointer points to.

Back-pressure works as follows. `wr_ready` is low exactly when the queue is full, and a write offered then is dropped. The engine may hold `tx_ready` low for as long as it wants. The head byte then stays put until the engine pops it or the host discards it. Both handshakes complete on a rising edge where valid and ready are both high. The `empty` and `full` flags are plain status pins.

Top module: `sc_tx_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `tx_valid`=0, `wr_ready`=1 and `tx_data`=0x00, because every slot resets to zero.
- R2: A write is accepted when `wr_valid` and `wr_ready` are both high at a rising edge. It stores `wr_data` at the tail. Bytes reach `tx_data` in the order they were written, and two accepted writes from empty make `full`=1.
- R3: `wr_ready` equals not `full`. A write offered while full is ignored: the queue contents, the flags and the later drained order are all unchanged.
- R4: `tx_valid` equals not `empty`, and `tx_data` shows the head byte. While `tx_valid`=1, `tx_ready`=0 and `rd_discard`=0, the head byte and `tx_valid` stay unchanged.
- R5: `tx_valid` and `tx_ready` both high at a rising edge remove the head entry. From the next cycle the following byte is shown, or `empty`=1 if no byte follows.
- R6: `rd_discard` high at a rising edge while not empty drops the head entry and returns no data. Two discards starting from full leave `empty`=1.
- R7: `rd_discard` while empty has no effect. The queue stays empty, and the next written byte becomes the head.
- R8: A pop and a discard in the same cycle remove exactly one entry.
- R9: Slots are never cleared. After the queue is filled with A then B and drained, the read pointer has wrapped to slot 0, so `tx_data` shows A.
- R10: An accepted write and a pop in the same cycle, with one entry held, leave one entry, and the new byte becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Queue can take a byte (not full) |
| wr_data | input | WIDTH | Byte from the host |
| rd_discard | input | 1 | Host read strobe: drop the head entry |
| tx_valid | output | 1 | Head byte available to the engine |
| tx_ready | input | 1 | Engine takes the head byte |
| tx_data | output | WIDTH | Head slot contents |
| empty | output | 1 | No entries held |
| full | output | 1 | All entries held |

## Verification
The queue is filled and drained under several patterns, and each one separates a different behaviour:
- Filling and popping in order shows whether ordering and the wrap bit are right.
- Filling and then offering one more write shows whether a write made while full leaks into a slot.
- Discards from full, and discards from empty, show whether a discard moves the pointer only when an entry exists.
- A pop and a discard in the same cycle show whether one or two entries are removed.
- A write and a pop in the same cycle show whether the count stays at one entry.

After each drain the stale head byte is compared with the last byte written to slot 0. This shows that slots are kept and not cleared.

// File: rtl/txf_pkg.sv
package txf_pkg;
  // What happens to the queue in one cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_PUSH  = 2'd1,
    ACT_TAKE  = 2'd2,
    ACT_BOTH  = 2'd3
  } txf_act_e;
endpackage

// File: rtl/txf_ptr_ctrl.sv
// Read/write pointers with one extra wrap bit; DEPTH must be a power of two.
module txf_ptr_ctrl
  import txf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            discard_req,
  output logic [$clog2(DEPTH):0] wr_ptr,
  output logic [$clog2(DEPTH):0] rd_ptr,
  output logic            empty,
  output logic            full,
  output logic            push_fire
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic     take_fire;
  txf_act_e act;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

  assign push_fire = push_req && !full;
  // pop and discard together still consume a single entry
  assign take_fire = (pop_req || discard_req) && !empty;

  always_comb begin
    act = txf_act_e'({take_fire, push_fire});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      unique case (act)
        ACT_PUSH: wr_ptr <= wr_ptr + PW'(1);
        ACT_TAKE: rd_ptr <= rd_ptr + PW'(1);
        ACT_BOTH: begin
          wr_ptr <= wr_ptr + PW'(1);
          rd_ptr <= rd_ptr + PW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txf_store.sv
// Slot storage: reset to zero, changed only by writes, never cleared on consume.
module txf_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH*WIDTH-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (we && (waddr == AW'(g)))
        slot_q <= wdata;
    end
    assign flat[g*WIDTH +: WIDTH] = slot_q;
  end

  assign rdata = flat[raddr*WIDTH +: WIDTH];
endmodule

// File: rtl/sc_tx_fifo.sv
module sc_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_discard,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [WIDTH-1:0] tx_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0] wr_ptr;
  logic [AW:0] rd_ptr;
  logic        push_fire;

  txf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_req    (wr_valid),
    .pop_req     (tx_ready),
    .discard_req (rd_discard),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .empty       (empty),
    .full        (full),
    .push_fire   (push_fire)
  );

  txf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (push_fire),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (wr_data),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (tx_data)
  );

  assign wr_ready = !full;
  assign tx_valid = !empty;
endmodule

// File: rtl/sc_tx_fifo_chk.sv
module sc_tx_fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_discard,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [WIDTH-1:0] tx_data,
  input logic             empty,
  input logic             full
);
  // R1
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R3
  full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_ready);

  // R4
  empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !tx_valid);

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rd_discard) |=> (tx_valid && $stable(tx_data)));

  // R2
  push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_valid && wr_ready) |=> !empty);

  // R7
  discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_valid) |=> empty);

  // R3
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !tx_ready && !rd_discard) |=> full);
endmodule

bind sc_tx_fifo sc_tx_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_discard (rd_discard),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .empty      (empty),
  .full       (full)
);

// File: tb/tb_sc_tx_fifo.sv
module tb_sc_tx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic       rd_discard = 1'b0;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       empty;
  logic       full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sc_tx_fifo #(.WIDTH(8), .DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_discard(rd_discard), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .empty(empty), .full(full)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with given inputs; outputs checked 1 ns after the edge
  task automatic step(input logic wv, input logic [7:0] wd, input logic rdy, input logic disc);
    wr_valid = wv; wr_data = wd; tx_ready = rdy; rd_discard = disc;
    @(posedge clk); #1;
    wr_valid = 1'b0; tx_ready = 1'b0; rd_discard = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", {7'd0, empty}, 8'd1);
    chk("R1 full", {7'd0, full}, 8'd0);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
    chk("R1 wr_ready", {7'd0, wr_ready}, 8'd1);
    chk("R1 tx_data", tx_data, 8'h00);
  endtask

  task automatic t_order();
    step(1, 8'h11, 0, 0);
    chk("R2 head", tx_data, 8'h11);
    chk("R4 valid", {7'd0, tx_valid}, 8'd1);
    step(1, 8'h22, 0, 0);
    chk("R2 full", {7'd0, full}, 8'd1);
    chk("R3 wr_ready", {7'd0, wr_ready}, 8'd0);
    step(0, 8'h00, 0, 0);
    chk("R4 hold", tx_data, 8'h11);
    step(0, 8'h00, 1, 0);
    chk("R5 next", tx_data, 8'h22);
    chk("R5 not full", {7'd0, full}, 8'd0);
    step(0, 8'h00, 1, 0);
    chk("R5 empty", {7'd0, empty}, 8'd1);
    chk("R9 stale", tx_data, 8'h11);
  endtask

  task automatic t_full_ignore();
    step(1, 8'h33, 0, 0);
    step(1, 8'h44, 0, 0);
    step(1, 8'h55, 0, 0);
    chk("R3 still full", {7'd0, full}, 8'd1);
    chk("R3 head", tx_data, 8'h33);
    step(0, 8'h00, 1, 0);
    chk("R3 second", tx_data, 8'h44);
    step(0, 8'h00, 1, 0);
    chk("R3 empty", {7'd0, empty}, 8'd1);
    chk("R3 R9 stale", tx_data, 8'h33);
  endtask

  task automatic t_discard();
    step(1, 8'h66, 0, 0);
    step(1, 8'h77, 0, 0);
    step(0, 8'h00, 0, 1);
    chk("R6 head", tx_data, 8'h77);
    chk("R6 not full", {7'd0, full}, 8'd0);
    step(0, 8'h00, 0, 1);
    chk("R6 empty", {7'd0, empty}, 8'd1);
    chk("R6 R9 stale", tx_data, 8'h66);
  endtask

  task automatic t_discard_empty();
    step(0, 8'h00, 0, 1);
    chk("R7 empty", {7'd0, empty}, 8'd1);
    step(1, 8'h88, 0, 0);
    chk("R7 head", tx_data, 8'h88);
    step(1, 8'h99, 0, 0);
    chk("R7 full", {7'd0, full}, 8'd1);
    step(0, 8'h00, 1, 0);
    chk("R7 second", tx_data, 8'h99);
    step(0, 8'h00, 1, 0);
    chk("R7 drained", {7'd0, empty}, 8'd1);
  endtask

  task automatic t_pop_discard();
    step(1, 8'hA1, 0, 0);
    step(1, 8'hA2, 0, 0);
    step(0, 8'h00, 1, 1);
    chk("R8 head", tx_data, 8'hA2);
    chk("R8 not empty", {7'd0, empty}, 8'd0);
    chk("R8 not full", {7'd0, full}, 8'd0);
    step(0, 8'h00, 1, 0);
    chk("R8 empty", {7'd0, empty}, 8'd1);
  endtask

  task automatic t_write_pop();
    step(1, 8'hB1, 0, 0);
    step(1, 8'hB2, 1, 0);
    chk("R10 head", tx_data, 8'hB2);
    chk("R10 not empty", {7'd0, empty}, 8'd0);
    chk("R10 not full", {7'd0, full}, 8'd0);
    step(0, 8'h00, 1, 0);
    chk("R10 empty", {7'd0, empty}, 8'd1);
  endtask

  initial begin
    #35 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_order();
    t_full_ignore();
    t_discard();
    t_discard_empty();
    t_pop_discard();
    t_write_pop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule